// File: doc/BRIEF.md
# Crank-Synchronous Injection and Ignition Scheduler

This block is the timing core of a small engine controller. A free-running up-counter advances once every `PRESCALE` system clocks and is the only time reference. Each edge from the distributor Hall sensor timestamps that counter. Of the two crank markers in each half revolution, one arrives as a rising edge and the other as a falling edge, so the polarity of the edge says which marker was seen. The block also reports the half-revolution period as the tick difference between two captures of the same polarity. At low engine speed the host takes both edges. At high speed it takes the rising edge only. Edges that come sooner than a programmable tick gap after the last accepted one are treated as noise.

Two compare channels drive the outputs. Channel A drives the injector group and its match events serve as the housekeeping tick. Channel B drives the ignition coil: it starts dwell, fires the spark and emits a strobe that opens the knock-integration window. Each channel holds one active entry and one pending entry. An entry is a match count and an action. On a match the channel applies the action and raises its flag. It then promotes the pending entry, or goes idle if there is none. The fuel pump relay turns on at the first capture and drops after two counter overflows with no capture. The host uses a flat register write/read port and four interrupt flags.

Top module: `crank_sched`

## Requirements
- R1: The count resets to 0 and increments by exactly one every `PRESCALE` clocks, wrapping from all-ones to 0.
- R2: The Hall input passes through two synchronizer flops. An accepted rising edge records polarity 1 and an accepted falling edge records polarity 0 (status register bit 0). The count at acceptance is latched as the timestamp.
- R3: When control bit 0 is 1, both edges are captured. When it is 0, falling edges are ignored and leave the flags, timestamp and polarity unchanged.
- R4: The period register holds the timestamp difference from the previous accepted capture of the same polarity, in ticks.
- R5: An edge arriving fewer than `min_gap` ticks after the last accepted capture is ignored.
- R6: Each accepted capture sets flag bit 0.
- R7: On a match, action code 1 drives the channel output high and code 2 drives it low. Code 3 gives a one-clock strobe (`sched_strobe` bit 0 for A, bit 1 for B) and leaves the output alone. Code 0 changes nothing. Every match sets the channel's flag (bit 1 for A, bit 2 for B).
- R8: Writing an action commits the staged match value and the action as the pending entry. An idle channel loads it at once. After a match the pending entry becomes active, and with none pending the channel goes idle and raises no further match.
- R9: A commit that lands in the same clock as a match is kept as the next entry. The matching entry still applies its own action.
- R10: The pump output is 0 after reset and goes to 1 on any accepted capture. It drops to 0 at the second overflow with no capture in between, and that drop sets flag bit 3.
- R11: Writing 1s to address 6 clears those flag bits only. A flag being set in the same clock wins over the clear.
- R12: Read addresses: 0 control, 1 min gap, 2 timestamp, 3 period, 4 status (bit 1 pump, bit 0 polarity), 5 live count, 6 flags. Write addresses: 0 control, 1 min gap, 2/3 A match/action, 4/5 B match/action, 6 flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_in | input | 1 | Raw distributor Hall sensor level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| inj_out | output | 1 | Injector group drive (channel A) |
| coil_out | output | 1 | Ignition coil drive (channel B) |
| sched_strobe | output | 2 | One-clock action strobes; bit 1 opens the knock window |
| pump_on | output | 1 | Fuel pump relay drive |
| irq_flags | output | 4 | Capture, match A, match B, stall |

## Verification
The collision covered is a host commit on channel A arriving in the very clock that the active entry matches. The bench polls the live count and waits for the first falling clock edge at which the count equals the match value, which is the cycle the match fires. In that cycle it issues the action write. The result is judged on two points. The old entry's clear action must appear on `inj_out`. The newly committed set action must then fire four ticks later rather than being lost when the matched entry is retired.

// File: rtl/crank_sched_pkg.sv
package crank_sched_pkg;

    localparam int HOST_W = 16;
    localparam int NFLAGS = 4;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_SET   = 2'd1,
        ACT_CLR   = 2'd2,
        ACT_PULSE = 2'd3
    } cmp_act_e;

    typedef struct packed {
        logic [HOST_W-1:0] match;
        cmp_act_e          act;
    } cmp_entry_t;

    localparam logic [2:0] REG_CTRL    = 3'd0;
    localparam logic [2:0] REG_GAP     = 3'd1;
    localparam logic [2:0] REG_A_MATCH = 3'd2;
    localparam logic [2:0] REG_A_ACT   = 3'd3;
    localparam logic [2:0] REG_B_MATCH = 3'd4;
    localparam logic [2:0] REG_B_ACT   = 3'd5;
    localparam logic [2:0] REG_FLAGS   = 3'd6;

    localparam logic [2:0] RD_TS     = 3'd2;
    localparam logic [2:0] RD_PERIOD = 3'd3;
    localparam logic [2:0] RD_STAT   = 3'd4;
    localparam logic [2:0] RD_COUNT  = 3'd5;

    localparam int FLAG_CAP   = 0;
    localparam int FLAG_A     = 1;
    localparam int FLAG_B     = 2;
    localparam int FLAG_STALL = 3;

    function automatic logic next_level(cmp_act_e a, logic cur);
        case (a)
            ACT_SET: return 1'b1;
            ACT_CLR: return 1'b0;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/crank_timebase.sv
module crank_timebase #(
    parameter int PRESCALE = 64,
    parameter int TB_W     = 16
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TB_W-1:0] count,
    output logic            adv,
    output logic            ovf
);
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pre;
    logic          tick;

    assign tick = (pre == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre   <= '0;
            count <= '0;
            adv   <= 1'b0;
            ovf   <= 1'b0;
        end else begin
            adv <= tick;
            ovf <= tick && (count == '1);
            if (tick) begin
                pre   <= '0;
                count <= count + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

    assert_step_R1: assert property (@(posedge clk) disable iff (rst)
        adv |-> count == $past(count) + TB_W'(1));
    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !adv |-> $stable(count));
    assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (count == '0) && adv);

endmodule

// File: rtl/crank_capture.sv
module crank_capture #(
    parameter int TB_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hall_in,
    input  logic            both_edges,
    input  logic [TB_W-1:0] min_gap,
    input  logic [TB_W-1:0] count,
    input  logic            adv,
    output logic            cap_evt,
    output logic [TB_W-1:0] cap_ts,
    output logic [TB_W-1:0] cap_period,
    output logic            cap_pol
);
    logic            s1, s2, s_q;
    logic            rise, fall, want, accept;
    logic [TB_W-1:0] since;
    logic [TB_W-1:0] last_ts [2];
    logic [1:0]      seen;

    assign rise   = s2 && !s_q;
    assign fall   = !s2 && s_q;
    assign want   = both_edges ? (rise || fall) : rise;
    assign accept = want && (since >= min_gap);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1         <= 1'b0;
            s2         <= 1'b0;
            s_q        <= 1'b0;
            cap_evt    <= 1'b0;
            cap_ts     <= '0;
            cap_period <= '0;
            cap_pol    <= 1'b0;
            since      <= '1;
            seen       <= '0;
            last_ts[0] <= '0;
            last_ts[1] <= '0;
        end else begin
            s1      <= hall_in;
            s2      <= s1;
            s_q     <= s2;
            cap_evt <= accept;
            if (accept) begin
                since         <= '0;
                cap_ts        <= count;
                cap_pol       <= rise;
                last_ts[rise] <= count;
                seen[rise]    <= 1'b1;
                if (seen[rise])
                    cap_period <= count - last_ts[rise];
            end else if (adv && (since != '1)) begin
                since <= since + 1'b1;
            end
        end
    end

    assert_one_edge_R3: assert property (@(posedge clk) disable iff (rst)
        cap_evt && !$past(both_edges) |-> cap_pol);
    assert_gap_R5: assert property (@(posedge clk) disable iff (rst)
        cap_evt && (min_gap != '0) |=> !cap_evt);
    assert_ts_stable_R2: assert property (@(posedge clk) disable iff (rst)
        !cap_evt |-> $stable(cap_ts));

endmodule

// File: rtl/crank_cmp_chan.sv
module crank_cmp_chan
    import crank_sched_pkg::*;
#(
    parameter int TB_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TB_W-1:0] count,
    input  logic            adv,
    input  logic            commit,
    input  cmp_entry_t      commit_entry,
    output logic            out_lvl,
    output logic            strobe,
    output logic            match_evt
);
    cmp_entry_t cur;
    cmp_entry_t pend;
    logic       armed;
    logic       pend_v;
    logic       hit;
    logic       retire;

    assign hit    = armed && adv && (HOST_W'(count) == cur.match);
    assign retire = hit || !armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            pend      <= '0;
            armed     <= 1'b0;
            pend_v    <= 1'b0;
            out_lvl   <= 1'b0;
            strobe    <= 1'b0;
            match_evt <= 1'b0;
        end else begin
            match_evt <= hit;
            strobe    <= hit && (cur.act == ACT_PULSE);
            if (hit)
                out_lvl <= next_level(cur.act, out_lvl);
            if (retire) begin
                if (pend_v) begin
                    cur   <= pend;
                    armed <= 1'b1;
                end else begin
                    armed <= 1'b0;
                end
            end
            if (commit)
                pend <= commit_entry;
            pend_v <= commit ? 1'b1 : (retire ? 1'b0 : pend_v);
        end
    end

    assert_set_R7: assert property (@(posedge clk) disable iff (rst)
        hit && (cur.act == ACT_SET) |=> out_lvl);
    assert_clr_R7: assert property (@(posedge clk) disable iff (rst)
        hit && (cur.act == ACT_CLR) |=> !out_lvl);
    assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        hit && (cur.act == ACT_PULSE) |=> strobe && $stable(out_lvl));
    assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(out_lvl) && !strobe && !match_evt);
    assert_keep_R9: assert property (@(posedge clk) disable iff (rst)
        hit && commit |=> armed || pend_v);

endmodule

// File: rtl/crank_sched.sv
module crank_sched
    import crank_sched_pkg::*;
#(
    parameter int PRESCALE = 64,
    parameter int TB_W     = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hall_in,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [HOST_W-1:0]   wr_data,
    input  logic [2:0]          rd_addr,
    output logic [HOST_W-1:0]   rd_data,
    output logic                inj_out,
    output logic                coil_out,
    output logic [1:0]          sched_strobe,
    output logic                pump_on,
    output logic [NFLAGS-1:0]   irq_flags
);
    logic [TB_W-1:0]   count;
    logic              adv, ovf;
    logic              both_edges;
    logic [TB_W-1:0]   min_gap;
    logic              cap_evt, cap_pol;
    logic [TB_W-1:0]   cap_ts, cap_period;
    logic [HOST_W-1:0] stage_a, stage_b;
    logic              a_evt, b_evt;
    logic              commit_a, commit_b;
    cmp_entry_t        entry_a, entry_b;
    logic [1:0]        ovf_cnt;
    logic              stall_evt;
    logic [NFLAGS-1:0] set_mask, clr_mask;

    crank_timebase #(.PRESCALE(PRESCALE), .TB_W(TB_W)) u_tb (
        .clk(clk), .rst(rst), .count(count), .adv(adv), .ovf(ovf)
    );

    crank_capture #(.TB_W(TB_W)) u_cap (
        .clk(clk), .rst(rst), .hall_in(hall_in), .both_edges(both_edges),
        .min_gap(min_gap), .count(count), .adv(adv), .cap_evt(cap_evt),
        .cap_ts(cap_ts), .cap_period(cap_period), .cap_pol(cap_pol)
    );

    assign commit_a = wr_en && (wr_addr == REG_A_ACT);
    assign commit_b = wr_en && (wr_addr == REG_B_ACT);
    assign entry_a  = '{match: stage_a, act: cmp_act_e'(wr_data[1:0])};
    assign entry_b  = '{match: stage_b, act: cmp_act_e'(wr_data[1:0])};

    crank_cmp_chan #(.TB_W(TB_W)) u_chan_a (
        .clk(clk), .rst(rst), .count(count), .adv(adv), .commit(commit_a),
        .commit_entry(entry_a), .out_lvl(inj_out), .strobe(sched_strobe[0]),
        .match_evt(a_evt)
    );

    crank_cmp_chan #(.TB_W(TB_W)) u_chan_b (
        .clk(clk), .rst(rst), .count(count), .adv(adv), .commit(commit_b),
        .commit_entry(entry_b), .out_lvl(coil_out), .strobe(sched_strobe[1]),
        .match_evt(b_evt)
    );

    assign stall_evt = pump_on && ovf && (ovf_cnt == 2'd1) && !cap_evt;
    assign set_mask  = {stall_evt, b_evt, a_evt, cap_evt};
    assign clr_mask  = (wr_en && (wr_addr == REG_FLAGS)) ? wr_data[NFLAGS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            both_edges <= 1'b0;
            min_gap    <= '0;
            stage_a    <= '0;
            stage_b    <= '0;
            irq_flags  <= '0;
            pump_on    <= 1'b0;
            ovf_cnt    <= '0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    REG_CTRL:    both_edges <= wr_data[0];
                    REG_GAP:     min_gap    <= wr_data[TB_W-1:0];
                    REG_A_MATCH: stage_a    <= wr_data;
                    REG_B_MATCH: stage_b    <= wr_data;
                    default: ;
                endcase
            end
            irq_flags <= (irq_flags & ~clr_mask) | set_mask;
            if (cap_evt) begin
                ovf_cnt <= '0;
                pump_on <= 1'b1;
            end else if (ovf) begin
                if (ovf_cnt == 2'd1)
                    pump_on <= 1'b0;
                if (ovf_cnt != 2'd2)
                    ovf_cnt <= ovf_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        case (rd_addr)
            REG_CTRL:  rd_data = HOST_W'(both_edges);
            REG_GAP:   rd_data = HOST_W'(min_gap);
            RD_TS:     rd_data = HOST_W'(cap_ts);
            RD_PERIOD: rd_data = HOST_W'(cap_period);
            RD_STAT:   rd_data = HOST_W'({pump_on, cap_pol});
            RD_COUNT:  rd_data = HOST_W'(count);
            REG_FLAGS: rd_data = HOST_W'(irq_flags);
            default:   rd_data = '0;
        endcase
    end

    assert_pump_on_R10: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> pump_on);
    assert_pump_off_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(pump_on) |-> $past(ovf) && irq_flags[FLAG_STALL]);
    assert_cap_flag_R6: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> irq_flags[FLAG_CAP]);
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        a_evt |=> irq_flags[FLAG_A]);

endmodule

// File: tb/crank_sched_bench.sv
module crank_sched_bench;
    localparam int CLK_P = 10;
    localparam int PRE   = 4;
    localparam int TBW   = 12;
    localparam int MASK  = (1 << TBW) - 1;

    // {action[1:0], expected inj_out, expected strobe}
    localparam logic [3:0] VEC [5] = '{4'b01_1_0, 4'b10_0_0, 4'b11_0_1, 4'b01_1_0, 4'b00_1_0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hall_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        inj_out, coil_out, pump_on;
    logic [1:0]  sched_strobe;
    logic [3:0]  irq_flags;

    int checks = 0;
    int errors = 0;
    int strb_a = 0;
    int strb_b = 0;

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        if (sched_strobe[0]) strb_a++;
        if (sched_strobe[1]) strb_b++;
    end

    crank_sched #(.PRESCALE(PRE), .TB_W(TBW)) u_crank_sched (
        .clk(clk), .rst(rst), .hall_in(hall_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .inj_out(inj_out),
        .coil_out(coil_out), .sched_strobe(sched_strobe), .pump_on(pump_on),
        .irq_flags(irq_flags)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_flag(input int bitn, output bit seen);
        int v;
        seen = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            rd(3'd6, v);
            if (v[bitn]) begin seen = 1'b1; break; end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v, c, ts1, m, sa, sb, t;
        bit seen;
        clocks(4);
        rst = 1'b0;
        @(negedge clk);
        // R1 / R10 reset state
        rd(3'd5, v); chk(v <= 1, "R1 count after reset", v, 0);
        chk(pump_on == 1'b0, "R10 pump off at reset", pump_on, 0);
        chk(irq_flags == 4'd0 && inj_out == 1'b0 && coil_out == 1'b0, "R7 outputs at reset",
            {irq_flags, inj_out, coil_out}, 0);
        // R1 rate
        rd(3'd5, c); clocks(40); rd(3'd5, v);
        chk(((v - c) & MASK) == 10, "R1 tick rate", (v - c) & MASK, 10);
        // R12 readback
        wr(3'd1, 0); wr(3'd0, 1);
        rd(3'd0, v); chk(v == 1, "R12 control readback", v, 1);

        // R7 vector walk on channel A
        for (int i = 0; i < 5; i++) begin
            sa = strb_a;
            rd(3'd5, c);
            wr(3'd2, (c + 6) & MASK);
            wr(3'd3, int'(VEC[i][3:2]));
            wait_flag(1, seen);
            clocks(2);
            chk(seen, "R7 match flag A", seen, 1);
            chk(inj_out == VEC[i][1], "R7 injector level", inj_out, VEC[i][1]);
            chk((strb_a - sa) == int'(VEC[i][0]), "R7 strobe count", strb_a - sa, VEC[i][0]);
            wr(3'd6, 2);
        end

        // R8 chained entries on channel B
        sb = strb_b;
        rd(3'd5, c);
        wr(3'd4, (c + 6) & MASK); wr(3'd5, 1);
        wr(3'd4, (c + 11) & MASK); wr(3'd5, 3);
        clocks(4 * 14);
        chk(coil_out == 1'b1, "R8 dwell start on coil", coil_out, 1);
        chk((strb_b - sb) == 1, "R8 knock strobe from pending entry", strb_b - sb, 1);
        wr(3'd6, 4);
        clocks(4 * 30);
        rd(3'd6, v);
        chk(v[2] == 1'b0, "R8 idle channel raises no match", v[2], 0);
        rd(3'd5, c);
        wr(3'd4, (c + 5) & MASK); wr(3'd5, 2);
        clocks(4 * 8);
        chk(coil_out == 1'b0, "R7 spark clears coil", coil_out, 0);

        // R9 commit in the cycle of a match
        rd(3'd5, c);
        m = (c + 8) & MASK;
        wr(3'd2, m); wr(3'd3, 2);
        wr(3'd2, (m + 4) & MASK);
        t = 0;
        do begin
            @(negedge clk); rd(3'd5, v); t++;
        end while (v != m && t < 200);
        wr(3'd3, 1);
        clocks(4);
        chk(inj_out == 1'b0, "R9 old entry applied", inj_out, 0);
        clocks(4 * 5);
        chk(inj_out == 1'b1, "R9 late commit kept", inj_out, 1);
        wr(3'd6, 15);

        // R2 R4 R6 captures, both edges
        hall_in = 1'b1; clocks(8);
        rd(3'd2, ts1);
        rd(3'd6, v); chk(v[0] == 1'b1, "R6 capture flag", v[0], 1);
        rd(3'd4, v); chk(v[0] == 1'b1, "R2 rising polarity", v[0], 1);
        chk(pump_on == 1'b1, "R10 pump on after capture", pump_on, 1);
        clocks(32);
        hall_in = 1'b0; clocks(8);
        rd(3'd4, v); chk(v[0] == 1'b0, "R2 falling polarity", v[0], 0);
        clocks(32);
        hall_in = 1'b1; clocks(8);
        rd(3'd3, v); chk(v == 20, "R4 half-rev period", v, 20);
        rd(3'd2, t); chk(((t - ts1) & MASK) == 20, "R2 timestamp step", (t - ts1) & MASK, 20);

        // R3 rising-only mode
        wr(3'd0, 0); wr(3'd6, 1);
        clocks(30);
        hall_in = 1'b0; clocks(12);
        rd(3'd6, v); chk(v[0] == 1'b0, "R3 falling ignored", v[0], 0);
        rd(3'd2, c); chk(c == t, "R3 timestamp unchanged", c, t);
        clocks(28);
        hall_in = 1'b1; clocks(8);
        rd(3'd6, v); chk(v[0] == 1'b1, "R3 rising captured", v[0], 1);

        // R5 minimum gap
        wr(3'd0, 1); wr(3'd1, 20); wr(3'd6, 1);
        hall_in = 1'b0; clocks(12);
        rd(3'd6, v); chk(v[0] == 1'b0, "R5 close edge ignored", v[0], 0);
        rd(3'd4, v); chk(v[0] == 1'b1, "R5 polarity unchanged", v[0], 1);
        clocks(100);
        hall_in = 1'b1; clocks(8);
        rd(3'd6, v); chk(v[0] == 1'b1, "R5 spaced edge accepted", v[0], 1);

        // R10 stall shutoff
        wr(3'd6, 15);
        t = 0;
        while (pump_on && t < 40000) begin @(negedge clk); t++; end
        chk(pump_on == 1'b0, "R10 pump dropped on stall", pump_on, 0);
        chk(t > 4096 * PRE - 200, "R10 pump held through first overflow", t, 4096 * PRE);
        rd(3'd6, v); chk(v[3] == 1'b1, "R10 stall flag", v[3], 1);
        // R11 selective clear
        wr(3'd6, 1);
        rd(3'd6, v); chk(v[3] == 1'b1, "R11 other flag kept", v[3], 1);
        wr(3'd6, 8);
        rd(3'd6, v); chk(v[3] == 1'b0, "R11 flag cleared", v[3], 0);
        hall_in = 1'b0; clocks(8);
        chk(pump_on == 1'b1, "R10 capture restores pump", pump_on, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule